// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This combinational block forms the second ALU operand of a 32-bit RISC datapath. It picks one of three operand sources: a ready-made 32-bit immediate, a register shifted by a 5-bit amount held in the instruction, or a register shifted by an amount taken from the low byte of a second register. For the two shifted sources it applies one of five shift kinds and reports the shifter carry-out that a later flag stage may consume.

The shift rules track the classic carry behaviour exactly. A zero amount passes the value and the incoming carry through. An amount of exactly the word width shifts everything out. Larger amounts clear or sign-fill the result. Rotate reduces its amount modulo the word width. Rotate-extended feeds the incoming carry into the top bit. When the shifted register is the program counter, the block adds the pipeline offset of two instruction lengths before shifting.

Top module: `operand_shifter`

## Requirements
- R1: With `op_variant` = 0, `operand` equals `imm_val` and `carry_out` equals `carry_in`, whatever the other inputs are.
- R2: Logical left (`shift_kind` = 0), amount n from 1 to 32: result is source << n and carry is source bit 32-n. Amount above 32: result 0 and carry 0.
- R3: Logical right (`shift_kind` = 1), amount n from 1 to 32: result is source >> n and carry is source bit n-1. Amount above 32: result 0 and carry 0.
- R4: Arithmetic right (`shift_kind` = 2), amount n from 1 to 31: vacated bits take source bit 31 and carry is source bit n-1. Amount 32 or more: every result bit and the carry equal source bit 31.
- R5: Rotate right (`shift_kind` = 3), nonzero amount: the source is rotated right by the amount modulo 32, and the carry equals bit 31 of the result. A zero amount passes the source and `carry_in` through.
- R6: Rotate extended (`shift_kind` = 4), regardless of amount: the result is {`carry_in`, source[31:1]} and the carry is source bit 0.
- R7: A zero amount with `shift_kind` 0, 1 or 2 passes the source unchanged and gives `carry_out` = `carry_in`.
- R8: With `op_variant` = 1 the amount is `shift_imm` (0 to 31). With `op_variant` = 2 it is `rs_val[7:0]`, and `rs_val[31:8]` has no effect.
- R9: For `op_variant` 1 or 2, when `rm_is_pc` is 1 the source is `rm_val` + 8, or `rm_val` + 4 when `half_instr` is 1. When `rm_is_pc` is 0 the source is `rm_val`.
- R10: `shift_kind` values 5 to 7 pass the source through with `carry_out` = `carry_in`. `op_variant` = 3 gives an all-ones operand with `carry_out` = `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_variant | input | 2 | Operand source: 0 immediate, 1 register by immediate amount, 2 register by register amount |
| shift_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| imm_val | input | 32 | Pre-expanded immediate operand |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Register supplying the shift amount (low byte used) |
| shift_imm | input | 5 | Shift amount held in the instruction |
| rm_is_pc | input | 1 | Shifted register is the program counter |
| half_instr | input | 1 | Processor is in 16-bit instruction state |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Resulting operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so any wrong internal value shows on `operand` or `carry_out` in the same evaluation as the input that caused it. The bench sweeps every shift kind against amounts clustered around 0, 31, 32 and 33, plus large register amounts. A bad boundary comparison or a wrong carry-bit index therefore shows up as a single mismatched bit at a known amount. PC-offset and amount-source errors show up as shifted or offset results in the register variants.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int DW        = 32,
  parameter int AMT_W     = 8,
  parameter int IMM_AMT_W = 5
) (
  input  logic [1:0]           op_variant,
  input  logic [2:0]           shift_kind,
  input  logic [DW-1:0]        imm_val,
  input  logic [DW-1:0]        rm_val,
  input  logic [DW-1:0]        rs_val,
  input  logic [IMM_AMT_W-1:0] shift_imm,
  input  logic                 rm_is_pc,
  input  logic                 half_instr,
  input  logic                 carry_in,
  output logic [DW-1:0]        operand,
  output logic                 carry_out
);
  localparam int ROT_W = $clog2(DW);
  localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DW);

  logic [DW-1:0]        src;
  logic [AMT_W-1:0]     amt;
  logic [DW:0]          lsl_w;
  logic [DW:0]          lsr_w;
  logic signed [DW:0]   asr_w;
  logic [ROT_W-1:0]     rot;
  logic [DW-1:0]        ror_w;
  logic [DW-1:0]        sh_res;
  logic                 sh_c;

  assign src   = rm_is_pc ? rm_val + (half_instr ? DW'(4) : DW'(8)) : rm_val;
  assign amt   = (op_variant == 2'd1) ? AMT_W'(shift_imm) : rs_val[AMT_W-1:0];
  assign lsl_w = {1'b0, src} << amt;
  assign lsr_w = {src, 1'b0} >> amt;
  assign asr_w = $signed({src, 1'b0}) >>> amt;
  assign rot   = amt[ROT_W-1:0];
  assign ror_w = (src >> rot) | (src << (DW - int'(rot)));

  always_comb begin
    sh_res = src;
    sh_c   = carry_in;
    unique case (shift_kind)
      3'd0: if (amt != '0) begin
        if (amt <= AMT_FULL) {sh_c, sh_res} = lsl_w;
        else begin sh_res = '0; sh_c = 1'b0; end
      end
      3'd1: if (amt != '0) begin
        if (amt <= AMT_FULL) begin sh_res = lsr_w[DW:1]; sh_c = lsr_w[0]; end
        else begin sh_res = '0; sh_c = 1'b0; end
      end
      3'd2: if (amt != '0) begin
        sh_res = asr_w[DW:1];
        sh_c   = asr_w[0];
      end
      3'd3: if (amt != '0) begin
        sh_res = ror_w;
        sh_c   = ror_w[DW-1];
      end
      3'd4: begin
        sh_res = {carry_in, src[DW-1:1]};
        sh_c   = src[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op_variant)
      2'd0:       begin operand = imm_val; carry_out = carry_in; end
      2'd1, 2'd2: begin operand = sh_res;  carry_out = sh_c;     end
      default:    begin operand = '1;      carry_out = carry_in; end
    endcase
  end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int DW        = 32,
  parameter int IMM_AMT_W = 5
) (
  input logic [1:0]           op_variant,
  input logic [2:0]           shift_kind,
  input logic [DW-1:0]        imm_val,
  input logic [DW-1:0]        rm_val,
  input logic [DW-1:0]        rs_val,
  input logic [IMM_AMT_W-1:0] shift_imm,
  input logic                 rm_is_pc,
  input logic                 carry_in,
  input logic [DW-1:0]        operand,
  input logic                 carry_out
);
  logic reg_var, amt_zero;
  assign reg_var  = (op_variant == 2'd1) || (op_variant == 2'd2);
  assign amt_zero = (op_variant == 2'd1) ? (shift_imm == '0) : (rs_val[7:0] == 8'd0);

  always_comb begin
    if (op_variant == 2'd0)
      AST_IMM_PASS: assert (operand == imm_val && carry_out == carry_in) else $error("imm pass"); // R1
    if (op_variant == 2'd2 && shift_kind == 3'd0 && rs_val[7:0] > 8'd32)
      AST_LSL_CLEAR: assert (operand == '0 && !carry_out) else $error("lsl clear"); // R2
    if (op_variant == 2'd2 && shift_kind == 3'd1 && rs_val[7:0] > 8'd32)
      AST_LSR_CLEAR: assert (operand == '0 && !carry_out) else $error("lsr clear"); // R3
    if (op_variant == 2'd2 && shift_kind == 3'd2 && rs_val[7:0] >= 8'd32 && !rm_is_pc)
      AST_ASR_FILL: assert (operand == {DW{rm_val[DW-1]}} && carry_out == rm_val[DW-1]) else $error("asr fill"); // R4
    if (reg_var && shift_kind == 3'd3 && !amt_zero)
      AST_ROR_CARRY: assert (carry_out == operand[DW-1]) else $error("ror carry"); // R5
    if (reg_var && shift_kind == 3'd4 && !rm_is_pc)
      AST_RRX_TOP: assert (operand[DW-1] == carry_in && carry_out == rm_val[0]) else $error("rrx"); // R6
    if (reg_var && shift_kind <= 3'd2 && amt_zero && !rm_is_pc)
      AST_ZERO_AMT: assert (operand == rm_val && carry_out == carry_in) else $error("zero amt"); // R7
    if (op_variant == 2'd3)
      AST_ALL_ONES: assert (operand == '1 && carry_out == carry_in) else $error("variant 3"); // R10
  end
endmodule

bind operand_shifter operand_shifter_chk #(.DW(DW), .IMM_AMT_W(IMM_AMT_W)) u_chk (
  .op_variant(op_variant), .shift_kind(shift_kind), .imm_val(imm_val),
  .rm_val(rm_val), .rs_val(rs_val), .shift_imm(shift_imm), .rm_is_pc(rm_is_pc),
  .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
);

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  op_variant;
  logic [2:0]  shift_kind;
  logic [31:0] imm_val, rm_val, rs_val;
  logic [4:0]  shift_imm;
  logic        rm_is_pc, half_instr, carry_in;
  logic [31:0] operand;
  logic        carry_out;

  int n_run  = 0;
  int n_fail = 0;

  operand_shifter u_dut (
    .op_variant(op_variant), .shift_kind(shift_kind), .imm_val(imm_val),
    .rm_val(rm_val), .rs_val(rs_val), .shift_imm(shift_imm), .rm_is_pc(rm_is_pc),
    .half_instr(half_instr), .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] v,
                                        input int a, input logic c);
    logic [31:0] r;
    logic co;
    r = v; co = c;
    case (k)
      3'd0: if (a > 0 && a <= 32) begin
        for (int i = 0; i < 32; i++) r[i] = (i - a >= 0) ? v[i - a] : 1'b0;
        co = v[32 - a];
      end else if (a > 32) begin r = 0; co = 0; end
      3'd1: if (a > 0 && a <= 32) begin
        for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? v[i + a] : 1'b0;
        co = v[a - 1];
      end else if (a > 32) begin r = 0; co = 0; end
      3'd2: if (a > 0 && a < 32) begin
        for (int i = 0; i < 32; i++) r[i] = (i + a < 32) ? v[i + a] : v[31];
        co = v[a - 1];
      end else if (a >= 32) begin r = {32{v[31]}}; co = v[31]; end
      3'd3: if (a > 0) begin
        for (int i = 0; i < 32; i++) r[i] = v[(i + a % 32) % 32];
        co = r[31];
      end
      3'd4: begin r = {c, v[31:1]}; co = v[0]; end
      default: ;
    endcase
    return {co, r};
  endfunction

  function automatic string tag_of(input logic [2:0] k, input int a);
    if (k <= 3'd2 && a == 0) return "R7";
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_op, input logic exp_c);
    #2;
    n_run++;
    if (operand !== exp_op || carry_out !== exp_c) begin
      n_fail++;
      $display("FAIL %s: var=%0d kind=%0d rm=%h rs=%h imm=%0d pc=%b half=%b cin=%b got %h/%b exp %h/%b",
               tag, op_variant, shift_kind, rm_val, rs_val, shift_imm, rm_is_pc, half_instr,
               carry_in, operand, carry_out, exp_op, exp_c);
    end
    #2;
  endtask

  task automatic drive_reg(input logic [1:0] v, input logic [2:0] k, input logic [31:0] rm,
                           input logic [31:0] rs, input logic [4:0] si, input logic pc,
                           input logic half, input logic c, input string tag);
    logic [31:0] src;
    int a;
    logic [32:0] e;
    @(negedge clk);
    op_variant = v; shift_kind = k; rm_val = rm; rs_val = rs; shift_imm = si;
    rm_is_pc = pc; half_instr = half; carry_in = c; imm_val = 32'h0BAD_F00D;
    src = pc ? rm + (half ? 32'd4 : 32'd8) : rm;
    a = (v == 2'd1) ? int'(si) : int'(rs[7:0]);
    e = model(k, src, a, c);
    check(tag.len() > 0 ? tag : tag_of(k, a), e[31:0], e[32]);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    automatic int amts[12] = '{0, 1, 2, 5, 16, 31, 32, 33, 40, 64, 128, 255};
    automatic logic [31:0] vals[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_3C5A, 32'hFFFF_FFFF};

    op_variant = 0; shift_kind = 0; imm_val = 32'h1234_5678; rm_val = 0; rs_val = 0;
    shift_imm = 0; rm_is_pc = 0; half_instr = 0; carry_in = 1;
    check("R1", 32'h1234_5678, 1'b1);

    // R1: immediate variant ignores shifter inputs
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        op_variant = 2'd0; shift_kind = 3'(k); imm_val = 32'hC0DE_0000 | 32'(k);
        rm_val = 32'hFFFF_0000; rs_val = 32'd3; carry_in = c[0];
        check("R1", 32'hC0DE_0000 | 32'(k), c[0]);
      end

    // R2..R7, R10: register amount sweep
    for (int k = 0; k < 8; k++)
      foreach (amts[ai])
        foreach (vals[vi])
          for (int c = 0; c < 2; c++)
            drive_reg(2'd2, 3'(k), vals[vi], 32'(amts[ai]), 5'd0, 1'b0, 1'b0, c[0], "");

    // R8: upper bits of rs_val have no effect; immediate amount sweep
    for (int k = 0; k < 5; k++) begin
      drive_reg(2'd2, 3'(k), 32'hA5C3_3C5A, 32'hFFFF_FF03, 5'd0, 1'b0, 1'b0, 1'b1, "R8");
      for (int s = 0; s < 32; s++)
        drive_reg(2'd1, 3'(k), 32'h9F00_0F61, 32'h0000_0000, 5'(s), 1'b0, 1'b0, s[0], "R8");
    end

    // R9: program counter offset in both instruction states
    for (int k = 0; k < 5; k++)
      for (int h = 0; h < 2; h++) begin
        drive_reg(2'd1, 3'(k), 32'h0000_1000, 32'd0, 5'd3, 1'b1, h[0], 1'b0, "R9");
        drive_reg(2'd2, 3'(k), 32'hFFFF_FFFC, 32'd1, 5'd0, 1'b1, h[0], 1'b1, "R9");
      end

    // R10: unused variant gives all ones
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      op_variant = 2'd3; shift_kind = 3'd1; rm_val = 32'h1; rs_val = 32'd4; carry_in = c[0];
      check("R10", 32'hFFFF_FFFF, c[0]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule